// File: doc/BRIEF.md
# Flag Offset Load Sequencer

This block holds the two thresholds that a synchronous buffer's partial-level flags compare against: an almost-empty offset (n) and an almost-full offset (m). Each offset is kept as a low byte and a high byte. Software-free hardware access is through the buffer's own data pins. While the load pin is held low, each write strobe takes the value on the data input bus into one offset byte. Each read strobe copies one offset byte onto the data output bus.

There is no address. A single two-bit rotating selector is shared by writes and reads and steps through the four bytes in a fixed cycle: empty low, empty high, full low, full high, then back to empty low. The selector keeps its position when the load pin goes high, so a later load session resumes at the next byte. Whether the load pin acts as a load control at all is decided by its level while reset is asserted. If it is high during reset, the pin is treated as a second write enable elsewhere in the buffer, and this sequencer stays idle with default offsets.

The sequencer runs on one clock, and write and read strobes are sampled on the same edge. The combined offsets are driven continuously to the flag logic.

Top module: `ofs_load_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, both offsets return to 7 (each low byte = 7, each high byte = 0), `dout` returns to 0 and `proto_err` to 0.
- R2: In programming mode, with `load_n` = 0 and `wen_n` = 0, successive clock edges write `din` into selector positions 0, 1, 2 and 3 in turn. Position 0 is `empty_ofs[DW-1:0]`, position 1 is `empty_ofs[OW-1:DW]`, position 2 is `full_ofs[DW-1:0]` and position 3 is `full_ofs[OW-1:DW]`. The new value appears on the outputs after that edge.
- R3: Every accepted write or read advances the selector by one, modulo 4, so the fifth write lands in the empty-offset low byte again.
- R4: While `load_n` is 1, no offset byte, `dout` or the selector changes. The next session continues at the position where the last one stopped.
- R5: In programming mode, with `load_n` = 0, `ren_a_n` = 0, `ren_b_n` = 0 and `wen_n` = 1, a clock edge copies the byte at the current selector position to `dout`, using the same order as R2. `dout` holds between reads.
- R6: A high-byte position stores only its low `OW-DW` bits. Higher `din` bits are dropped, and those bits read back as 0 on `dout`.
- R7: If a write and a read are both requested on one edge, the write is performed and the read is ignored (`dout` unchanged, selector +1 only). `proto_err` is 1 for the following cycle only, and is 0 after any edge with no such collision.
- R8: Programming mode is latched from the inverse of `load_n` while `rst_n` is low. If `load_n` was 1 during reset, all strobes are ignored, both offsets stay 7 and `dout` stays 0.
- R9: With `load_n` = 0, a write needs `wen_n` = 0 and a read needs both `ren_a_n` and `ren_b_n` = 0. With any other strobe combination the edge changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for write and read strobes |
| rst_n | input | 1 | Synchronous reset, active low; also samples the mode |
| load_n | input | 1 | Load session select, active low; low during reset selects programming mode |
| wen_n | input | 1 | Write strobe, active low |
| ren_a_n | input | 1 | First read strobe, active low |
| ren_b_n | input | 1 | Second read strobe, active low |
| din | input | DW | Data input bus, source of offset bytes |
| dout | output | DW | Offset readback bus |
| empty_ofs | output | OW | Combined almost-empty offset n |
| full_ofs | output | OW | Combined almost-full offset m |
| proto_err | output | 1 | One-cycle pulse after a simultaneous write and read |

## Verification
The selector position is never visible at the ports, so it can only be inferred by chaining accesses. The stimulus writes past the wrap point and leaves the session with the selector mid-cycle. It then raises `load_n` with strobes still active, and shows through the next reads that the sequence resumes where it stopped. A collision is placed at a known selector position, and the following read proves that the selector moved exactly once. A second reset with `load_n` high checks that programming mode is decided by the pin level during reset.

// File: rtl/ofs_load_seq.sv
module ofs_load_seq #(
  parameter int DW     = 9,
  parameter int OW     = 14,
  parameter int DEF_LO = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_n,
  input  logic          wen_n,
  input  logic          ren_a_n,
  input  logic          ren_b_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [OW-1:0] empty_ofs,
  output logic [OW-1:0] full_ofs,
  output logic          proto_err
);
  localparam int            HW      = OW - DW;
  localparam logic [DW-1:0] HI_MASK = DW'((1 << HW) - 1);
  localparam logic [DW-1:0] LO_RST  = DW'(DEF_LO);

  logic          prog_mode;
  logic [1:0]    sel;
  logic [DW-1:0] ofs_q [4];

  wire sess   = prog_mode & ~load_n;
  wire wr_acc = sess & ~wen_n;
  wire rd_acc = sess & ~ren_a_n & ~ren_b_n;
  wire [DW-1:0] wr_val = sel[0] ? (din & HI_MASK) : din;

  always_ff @(posedge clk) begin
    if (!rst_n) prog_mode <= ~load_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel       <= 2'd0;
      dout      <= '0;
      proto_err <= 1'b0;
      for (int k = 0; k < 4; k++) ofs_q[k] <= (k % 2 == 1) ? '0 : LO_RST;
    end else begin
      proto_err <= wr_acc & rd_acc;
      if (wr_acc) begin
        ofs_q[sel] <= wr_val;
        sel        <= sel + 2'd1;
      end else if (rd_acc) begin
        dout <= ofs_q[sel];
        sel  <= sel + 2'd1;
      end
    end
  end

  assign empty_ofs = {ofs_q[1][HW-1:0], ofs_q[0]};
  assign full_ofs  = {ofs_q[3][HW-1:0], ofs_q[2]};
endmodule

// File: rtl/ofs_load_seq_chk.sv
module ofs_load_seq_chk #(
  parameter int DW     = 9,
  parameter int OW     = 14,
  parameter int DEF_LO = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_n,
  input logic          wen_n,
  input logic          ren_a_n,
  input logic          ren_b_n,
  input logic [DW-1:0] dout,
  input logic [OW-1:0] empty_ofs,
  input logic [OW-1:0] full_ofs,
  input logic          proto_err,
  input logic          prog_mode,
  input logic [1:0]    sel
);
  localparam int HW = OW - DW;

  wire act  = rst_n && prog_mode && !load_n;
  wire both = act && !wen_n && !ren_a_n && !ren_b_n;

  // R8
  dual_mode_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |-> (empty_ofs == OW'(DEF_LO) && full_ofs == OW'(DEF_LO) && dout == '0));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && load_n) |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(dout) && $stable(sel)));

  // R9
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && wen_n && (ren_a_n || ren_b_n)) |=>
      ($stable(empty_ofs) && $stable(full_ofs) && $stable(dout) && $stable(sel)));

  // R7
  collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    both |=> (proto_err && $stable(dout)));

  // R7
  err_only_on_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !both) |=> !proto_err);

  // R3
  sel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && (!wen_n || (!ren_a_n && !ren_b_n))) |=> (sel == $past(sel) + 2'd1));

  // R6
  hi_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && wen_n && !ren_a_n && !ren_b_n && sel[0]) |=> (dout[DW-1:HW] == '0));
endmodule

bind ofs_load_seq ofs_load_seq_chk #(.DW(DW), .OW(OW), .DEF_LO(DEF_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_n(load_n), .wen_n(wen_n),
  .ren_a_n(ren_a_n), .ren_b_n(ren_b_n), .dout(dout),
  .empty_ofs(empty_ofs), .full_ofs(full_ofs), .proto_err(proto_err),
  .prog_mode(prog_mode), .sel(sel)
);

// File: tb/ofs_load_seq_test.sv
`timescale 1ns/1ps
module ofs_load_seq_test;
  localparam int DW = 9;
  localparam int OW = 14;
  localparam int NV = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_n = 1'b1, wen_n = 1'b1, ren_a_n = 1'b1, ren_b_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic [OW-1:0] empty_ofs, full_ofs;
  logic proto_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ofs_load_seq #(.DW(DW), .OW(OW), .DEF_LO(7)) uut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .wen_n(wen_n),
    .ren_a_n(ren_a_n), .ren_b_n(ren_b_n), .din(din), .dout(dout),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .proto_err(proto_err)
  );

  // {load_n, wen_n, ren_a_n, ren_b_n, din, exp empty, exp full, exp dout, exp err}
  localparam logic [50:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,1'b1, 9'h0A5, 14'h00A5, 14'h0007, 9'h000, 1'b0},
    {1'b0,1'b0,1'b1,1'b1, 9'h1FF, 14'h3EA5, 14'h0007, 9'h000, 1'b0},
    {1'b0,1'b0,1'b1,1'b1, 9'h123, 14'h3EA5, 14'h0123, 9'h000, 1'b0},
    {1'b0,1'b0,1'b1,1'b1, 9'h005, 14'h3EA5, 14'h0B23, 9'h000, 1'b0},
    {1'b0,1'b0,1'b1,1'b1, 9'h0F0, 14'h3EF0, 14'h0B23, 9'h000, 1'b0},
    {1'b1,1'b0,1'b0,1'b0, 9'h155, 14'h3EF0, 14'h0B23, 9'h000, 1'b0},
    {1'b0,1'b1,1'b0,1'b0, 9'h000, 14'h3EF0, 14'h0B23, 9'h01F, 1'b0},
    {1'b0,1'b1,1'b0,1'b0, 9'h000, 14'h3EF0, 14'h0B23, 9'h123, 1'b0},
    {1'b0,1'b1,1'b0,1'b0, 9'h000, 14'h3EF0, 14'h0B23, 9'h005, 1'b0},
    {1'b0,1'b1,1'b0,1'b0, 9'h000, 14'h3EF0, 14'h0B23, 9'h0F0, 1'b0},
    {1'b0,1'b1,1'b0,1'b1, 9'h000, 14'h3EF0, 14'h0B23, 9'h0F0, 1'b0},
    {1'b0,1'b1,1'b1,1'b1, 9'h0AA, 14'h3EF0, 14'h0B23, 9'h0F0, 1'b0},
    {1'b0,1'b0,1'b0,1'b0, 9'h00C, 14'h18F0, 14'h0B23, 9'h0F0, 1'b1},
    {1'b1,1'b1,1'b1,1'b1, 9'h000, 14'h18F0, 14'h0B23, 9'h0F0, 1'b0},
    {1'b0,1'b1,1'b0,1'b0, 9'h000, 14'h18F0, 14'h0B23, 9'h123, 1'b0}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 1, 2, 3: return "R2 R6";
      4:          return "R3";
      5:          return "R4";
      6, 7, 8, 9: return "R5 R6 R4";
      10, 11:     return "R9";
      12, 13:     return "R7";
      default:    return "R7 R3";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(logic ld, logic w, logic ra, logic rb, logic [DW-1:0] d);
    @(negedge clk);
    load_n = ld; wen_n = w; ren_a_n = ra; ren_b_n = rb; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(logic ld);
    @(negedge clk);
    rst_n = 1'b0; load_n = ld; wen_n = 1'b1; ren_a_n = 1'b1; ren_b_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; load_n = 1'b1;
    step(1'b1, 1'b1, 1'b1, 1'b1, '0);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    // R1 reset values
    chk("R1", "empty_ofs", 32'(empty_ofs), 32'h7);
    chk("R1", "full_ofs",  32'(full_ofs),  32'h7);
    chk("R1", "dout",      32'(dout),      32'h0);
    chk("R1", "proto_err", 32'(proto_err), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      v = VEC[i];
      step(v[50], v[49], v[48], v[47], v[46:38]);
      chk(vec_tag(i), $sformatf("vec%0d empty_ofs", i), 32'(empty_ofs), 32'(v[37:24]));
      chk(vec_tag(i), $sformatf("vec%0d full_ofs", i),  32'(full_ofs),  32'(v[23:10]));
      chk(vec_tag(i), $sformatf("vec%0d dout", i),      32'(dout),      32'(v[9:1]));
      chk(vec_tag(i), $sformatf("vec%0d proto_err", i), 32'(proto_err), 32'(v[0]));
    end

    // R8 dual-write-enable mode: strobes have no effect
    do_reset(1'b1);
    chk("R1", "empty_ofs after re-reset", 32'(empty_ofs), 32'h7);
    chk("R1", "full_ofs after re-reset",  32'(full_ofs),  32'h7);
    step(1'b0, 1'b0, 1'b1, 1'b1, 9'h1AB);
    step(1'b0, 1'b0, 1'b1, 1'b1, 9'h0CD);
    step(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
    chk("R8", "empty_ofs dual mode", 32'(empty_ofs), 32'h7);
    chk("R8", "full_ofs dual mode",  32'(full_ofs),  32'h7);
    chk("R8", "dout dual mode",      32'(dout),      32'h0);

    // R2 programming mode restored by reset with load_n low
    do_reset(1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 9'h033);
    chk("R2", "empty_ofs first write", 32'(empty_ofs), 32'h33);
    step(1'b0, 1'b1, 1'b0, 1'b0, 9'h000);
    chk("R5", "dout reads empty high default", 32'(dout), 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule